// File: doc/BRIEF.md
# Cascaded Interrupt Controller Pair

This block joins two eight-input priority interrupt controllers into one sixteen-line unit. Request lines 0 to 7 feed the primary controller. Lines 8 to 15 feed the secondary controller, whose own request output is wired into primary input 2. The primary controller drives a single level interrupt to the processor. The processor answers with a one-cycle acknowledge strobe, and the block returns an 8-bit vector one clock later. When the winning primary input is the cascade input, that vector comes from the secondary controller. When the selected request has gone away in the meantime, the vector is a spurious one: the vector base with the low three bits all set.

Software reaches both controllers through a small byte-wide port interface:
- Primary command/data ports are at 0x20/0x21.
- Secondary command/data ports are at 0xA0/0xA1.
- Trigger-mode bytes are at 0x4D0 (primary) and 0x4D1 (secondary). Each bit selects level (1) or edge (0) triggering for one input.

The programming sequence, the command decode and the rotating-priority search sit in submodules that the top instantiates.

Top module: `pic_cascade_pair`

## Requirements
- R1: After reset, `int_o` and `vec_valid_o` are low, the mask registers read 0xFF at ports 0x21 and 0xA1, and the trigger-mode bytes read 0x00.
- R2: A write to 0x4D0 or 0x4D1 sets the trigger-mode byte of the primary or secondary controller, and reading the same port returns it.
- R3: In edge mode (trigger bit 0), a rising line sets its request bit. The acknowledge clears that bit, and a line held high afterwards does not set it again: the request bits read 0 at the even port after OCW3 0x0A, and `int_o` stays low after an EOI.
- R4: In level mode (trigger bit 1), the request bit stays set through an acknowledge while the line is high. After an EOI the interrupt is raised again.
- R5: Dropping a request line clears its request bit within one clock.
- R6: `int_o` goes high for an unmasked request that is not blocked by an in-service input. It stays high until an acknowledge or an initialisation command, and it is low in the cycle after the acknowledge.
- R7: An acknowledge makes `vec_valid_o` high for exactly the next cycle. `vec_o` then equals the vector base plus the input number, and the input's in-service bit is set. In-service bits are read at the even port after OCW3 0x0B.
- R8: If the selected request bit is clear when the acknowledge arrives, `vec_o` is the vector base ORed with 7 and the in-service bits do not change.
- R9: A request on lines 8 to 15 reaches primary input 2. Its acknowledge returns the secondary vector base plus (line - 8). The cascade input drops when the secondary request bits are all clear.
- R10: A set bit in the mask register (odd port, written outside initialisation) keeps that input from raising `int_o`. Clearing the bit releases the request.
- R11: An in-service input blocks itself and every input of lower priority, but a higher-priority input still raises `int_o`. After reset or initialisation, input 0 is highest and input 7 is lowest.
- R12: OCW2 written to the even port (bits 4:3 = 00, bit 5 = EOI) clears an in-service bit. When bit 6 is set it clears input bits 2:0. When bit 6 is clear it clears the highest-priority in-service bit.
- R13: A write to the even port with bit 4 set starts initialisation. It clears mask, request and in-service bits and lowers `int_o`. The next odd-port write sets vector base bits 7:3, and two further odd-port writes end the sequence.
- R14: OCW2 with bits 7 and 6 set and bit 5 clear makes input bits 2:0 the lowest priority. The input after it becomes the highest.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | 16 | Request lines; bit 2 is superseded by the cascade path |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe, one cycle per byte |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr`, combinational |
| ack_i | input | 1 | Interrupt-acknowledge strobe, one cycle |
| int_o | output | 1 | Interrupt request to the processor, level |
| vec_o | output | 8 | Vector, valid with `vec_valid_o` |
| vec_valid_o | output | 1 | High for one cycle after `ack_i` |

## Verification
The assertions assume that an acknowledge strobe does not coincide with a command-port write to the same controller. They also assume that `ack_i` is a single-cycle pulse rather than a held level. The bench therefore issues port writes and acknowledges in separate cycles and always releases the strobe after one clock. Request lines change only on falling clock edges and stay stable for many cycles, so every edge the block sees is clean and lasts long enough to reach the cascade input.

// File: rtl/pic_pkg.sv
package pic_pkg;

   localparam int CMD_LSB = 3;

   typedef enum logic [1:0] {
      CMD_EOI   = 2'b00,
      CMD_RDSEL = 2'b01,
      CMD_INITA = 2'b10,
      CMD_INITB = 2'b11
   } cmd_kind_e;

   typedef enum logic [1:0] {
      PH_RUN  = 2'd0,
      PH_BASE = 2'd1,
      PH_CASC = 2'd2,
      PH_MODE = 2'd3
   } init_phase_e;

   function automatic cmd_kind_e cmd_kind(input logic [7:0] d);
      return cmd_kind_e'(d[CMD_LSB+1:CMD_LSB]);
   endfunction

endpackage

// File: rtl/pic_prio.sv
module pic_prio #(
   parameter int LINES = 8,
   parameter int IW    = $clog2(LINES)
) (
   input  logic [LINES-1:0] req,
   input  logic [LINES-1:0] blk,
   input  logic [IW-1:0]    base,
   output logic             found,
   output logic [IW-1:0]    idx
);

   generate
      if (LINES != (1 << IW)) begin : g_bad_lines
         $error("pic_prio: LINES must be a power of two");
      end
   endgenerate

   logic          stop;
   logic [IW-1:0] pos;

   always_comb begin
      found = 1'b0;
      idx   = '0;
      stop  = 1'b0;
      pos   = '0;
      for (int i = 0; i < LINES; i++) begin
         pos = base + IW'(i + 1);
         if (!stop) begin
            if (blk[pos]) begin
               stop = 1'b1;
            end else if (req[pos]) begin
               found = 1'b1;
               idx   = pos;
               stop  = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/pic_unit.sv
module pic_unit
   import pic_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 8,
   parameter int IW     = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LINES-1:0]  pin_i,
   input  logic              cmd_we,
   input  logic              data_we,
   input  logic              elcr_we,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ack_i,
   output logic              int_o,
   output logic [IW-1:0]     sel_o,
   output logic              pend_o,
   output logic [DATA_W-1:0] vec_o,
   output logic [LINES-1:0]  irr_o,
   output logic [LINES-1:0]  isr_o,
   output logic [LINES-1:0]  imr_o,
   output logic [LINES-1:0]  elcr_o,
   output logic              rsel_o
);

   localparam int VB_W = DATA_W - IW;

   generate
      if (LINES > DATA_W || DATA_W != 8) begin : g_bad_width
         $error("pic_unit: LINES must fit in an 8-bit data byte");
      end
   endgenerate

   logic [LINES-1:0] irr_q, isr_q, imr_q, elcr_q, pin_q;
   logic [LINES-1:0] irr_n, isr_n, imr_n, elcr_n;
   logic [VB_W-1:0]  vb_q, vb_n;
   logic [IW-1:0]    base_q, base_n, sel_q, sel_n;
   init_phase_e      ph_q, ph_n;
   logic             rsel_q, rsel_n, int_q, int_n, init_cmd;

   logic             req_found, eoi_found;
   logic [IW-1:0]    req_idx, eoi_idx;
   logic [IW-1:0]    cmd_irq;
   logic             pend;

   pic_prio #(.LINES(LINES), .IW(IW)) u_req_sel (
      .req  (irr_q & ~imr_q),
      .blk  (isr_q),
      .base (base_q),
      .found(req_found),
      .idx  (req_idx)
   );

   pic_prio #(.LINES(LINES), .IW(IW)) u_eoi_sel (
      .req  (isr_q),
      .blk  ('0),
      .base (base_q),
      .found(eoi_found),
      .idx  (eoi_idx)
   );

   assign cmd_irq = wdata[IW-1:0];
   assign pend    = irr_q[sel_q];

   always_comb begin
      irr_n    = irr_q;
      isr_n    = isr_q;
      imr_n    = imr_q;
      elcr_n   = elcr_q;
      vb_n     = vb_q;
      base_n   = base_q;
      ph_n     = ph_q;
      rsel_n   = rsel_q;
      init_cmd = 1'b0;

      for (int i = 0; i < LINES; i++) begin
         if (!pin_i[i])       irr_n[i] = 1'b0;
         else if (elcr_q[i])  irr_n[i] = 1'b1;
         else if (!pin_q[i])  irr_n[i] = 1'b1;
      end

      if (ack_i && pend) begin
         if (!elcr_q[sel_q]) irr_n[sel_q] = 1'b0;
         isr_n[sel_q] = 1'b1;
      end

      if (cmd_we) begin
         case (cmd_kind(wdata))
            CMD_EOI: begin
               if (wdata[5]) begin
                  if (wdata[6])       isr_n[cmd_irq] = 1'b0;
                  else if (eoi_found) isr_n[eoi_idx] = 1'b0;
                  if (wdata[7])       base_n = cmd_irq;
               end else if (wdata[6] && wdata[7]) begin
                  base_n = cmd_irq;
               end
            end
            CMD_RDSEL: begin
               if (wdata[1]) rsel_n = wdata[0];
            end
            default: begin
               init_cmd = 1'b1;
               ph_n     = PH_BASE;
               imr_n    = '0;
               isr_n    = '0;
               irr_n    = '0;
               base_n   = IW'(LINES - 1);
            end
         endcase
      end

      if (data_we) begin
         case (ph_q)
            PH_RUN:  imr_n = wdata[LINES-1:0];
            PH_BASE: begin
               vb_n = wdata[DATA_W-1:IW];
               ph_n = PH_CASC;
            end
            PH_CASC: ph_n = PH_MODE;
            default: ph_n = PH_RUN;
         endcase
      end

      if (elcr_we) elcr_n = wdata[LINES-1:0];

      sel_n = req_found ? req_idx : sel_q;
      if (ack_i || init_cmd) int_n = 1'b0;
      else if (req_found)    int_n = 1'b1;
      else                   int_n = int_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q  <= '0;
         isr_q  <= '0;
         imr_q  <= '1;
         elcr_q <= '0;
         pin_q  <= '0;
         vb_q   <= '0;
         base_q <= IW'(LINES - 1);
         sel_q  <= '0;
         ph_q   <= PH_RUN;
         rsel_q <= 1'b0;
         int_q  <= 1'b0;
      end else begin
         irr_q  <= irr_n;
         isr_q  <= isr_n;
         imr_q  <= imr_n;
         elcr_q <= elcr_n;
         pin_q  <= pin_i;
         vb_q   <= vb_n;
         base_q <= base_n;
         sel_q  <= sel_n;
         ph_q   <= ph_n;
         rsel_q <= rsel_n;
         int_q  <= int_n;
      end
   end

   assign int_o  = int_q;
   assign sel_o  = sel_q;
   assign pend_o = pend;
   assign vec_o  = pend ? {vb_q, sel_q} : {vb_q, {IW{1'b1}}};
   assign irr_o  = irr_q;
   assign isr_o  = isr_q;
   assign imr_o  = imr_q;
   assign elcr_o = elcr_q;
   assign rsel_o = rsel_q;

   // R5: a low line leaves no request bit behind one clock later
   p_drop_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_i != '1) |=> ((irr_q & ~$past(pin_i)) == '0));

   // R6: acknowledge takes the interrupt down
   p_ack_lowers_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> !int_q);

   // R7: a genuine acknowledge marks the selected input in service
   p_isr_on_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && pend && !cmd_we) |=> isr_q[$past(sel_q)]);

   // R10: with no unmasked request the interrupt cannot rise
   p_mask_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!int_q && ((irr_q & ~imr_q) == '0)) |=> !int_q);

endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair #(
   parameter int          LINES   = 8,
   parameter int          DATA_W  = 8,
   parameter int          ADDR_W  = 16,
   parameter int          CAS_PIN = 2,
   parameter logic [15:0] PRI_PORT  = 16'h0020,
   parameter logic [15:0] SEC_PORT  = 16'h00A0,
   parameter logic [15:0] MODE_PORT = 16'h04D0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [2*LINES-1:0]   irq_i,
   input  logic [ADDR_W-1:0]    io_addr,
   input  logic                 io_wr,
   input  logic [DATA_W-1:0]    io_wdata,
   output logic [DATA_W-1:0]    io_rdata,
   input  logic                 ack_i,
   output logic                 int_o,
   output logic [DATA_W-1:0]    vec_o,
   output logic                 vec_valid_o
);

   localparam int IW = $clog2(LINES);

   generate
      if (CAS_PIN >= LINES || ADDR_W < 16) begin : g_bad_cfg
         $error("pic_cascade_pair: cascade pin or address width out of range");
      end
   endgenerate

   logic [1:0][LINES-1:0]  pin_v, irr_v, isr_v, imr_v, elcr_v;
   logic [1:0][IW-1:0]     sel_v;
   logic [1:0][DATA_W-1:0] vec_v;
   logic [1:0]             int_v, pend_v, rsel_v, ack_v, ctl_hit;
   logic                   mode_hit;
   logic                   cas_q, cas_pend_q, sec_int_d, sec_rise, cas_ack;
   logic [DATA_W-1:0]      vec_q;
   logic                   vec_valid_q;
   logic                   unused_cas_line, unused_sec_sel;

   assign unused_cas_line = irq_i[CAS_PIN];
   assign unused_sec_sel  = ^{sel_v[1], pend_v[1]};

   assign ctl_hit[0] = (io_addr[ADDR_W-1:1] == ADDR_W'(PRI_PORT) >> 1);
   assign ctl_hit[1] = (io_addr[ADDR_W-1:1] == ADDR_W'(SEC_PORT) >> 1);
   assign mode_hit   = (io_addr[ADDR_W-1:1] == ADDR_W'(MODE_PORT) >> 1);

   assign cas_ack = ack_i && (sel_v[0] == IW'(CAS_PIN)) && pend_v[0];

   always_comb begin
      pin_v[0]          = irq_i[LINES-1:0];
      pin_v[0][CAS_PIN] = cas_q;
      pin_v[1]          = irq_i[2*LINES-1:LINES];
      ack_v[0]          = ack_i;
      ack_v[1]          = cas_ack;
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_ctl
         pic_unit #(.LINES(LINES), .DATA_W(DATA_W), .IW(IW)) u_unit (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin_i  (pin_v[g]),
            .cmd_we (io_wr && ctl_hit[g] && !io_addr[0]),
            .data_we(io_wr && ctl_hit[g] && io_addr[0]),
            .elcr_we(io_wr && mode_hit && (io_addr[0] == 1'(g))),
            .wdata  (io_wdata),
            .ack_i  (ack_v[g]),
            .int_o  (int_v[g]),
            .sel_o  (sel_v[g]),
            .pend_o (pend_v[g]),
            .vec_o  (vec_v[g]),
            .irr_o  (irr_v[g]),
            .isr_o  (isr_v[g]),
            .imr_o  (imr_v[g]),
            .elcr_o (elcr_v[g]),
            .rsel_o (rsel_v[g])
         );
      end
   endgenerate

   always_comb begin
      io_rdata = '0;
      for (int g = 0; g < 2; g++) begin
         if (ctl_hit[g]) begin
            if (io_addr[0])     io_rdata = DATA_W'(imr_v[g]);
            else if (rsel_v[g]) io_rdata = DATA_W'(isr_v[g]);
            else                io_rdata = DATA_W'(irr_v[g]);
         end
      end
      if (mode_hit) io_rdata = DATA_W'(elcr_v[io_addr[0]]);
   end

   assign sec_rise = int_v[1] && !sec_int_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sec_int_d   <= 1'b0;
         cas_pend_q  <= 1'b0;
         cas_q       <= 1'b0;
         vec_q       <= '0;
         vec_valid_q <= 1'b0;
      end else begin
         sec_int_d  <= int_v[1];
         cas_pend_q <= sec_rise;
         if (irr_v[1] == '0) cas_q <= 1'b0;
         else if (sec_rise)  cas_q <= 1'b0;
         else if (cas_pend_q) cas_q <= 1'b1;
         vec_valid_q <= ack_i;
         if (ack_i) vec_q <= cas_ack ? vec_v[1] : vec_v[0];
      end
   end

   assign int_o       = int_v[0];
   assign vec_o       = vec_q;
   assign vec_valid_o = vec_valid_q;

   // R7: the vector strobe follows the acknowledge by one cycle
   p_vec_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> vec_valid_o);

   // R7: no strobe without an acknowledge
   p_vec_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !vec_valid_o);

   // R8: a vanished primary request yields the spurious low bits
   p_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !pend_v[0]) |=> (vec_o[IW-1:0] == '1));

   // R9: the cascade input falls once the secondary has nothing pending
   p_cas_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_v[1] == '0) |=> !cas_q);

endmodule

// File: tb/tb_pic_cascade_pair.sv
module tb_pic_cascade_pair;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq = '0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        ack = 1'b0;
   logic        int_o;
   logic [7:0]  vec_o;
   logic        vec_valid_o;

   int n_chk = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   pic_cascade_pair dut (
      .clk(clk), .rst_n(rst_n), .irq_i(irq),
      .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .ack_i(ack), .int_o(int_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
   );

   // {line[3:0], level, expected vector[7:0]}
   localparam logic [12:0] TAB [7] = '{
      {4'd0,  1'b0, 8'h20},
      {4'd5,  1'b1, 8'h25},
      {4'd7,  1'b0, 8'h27},
      {4'd9,  1'b0, 8'h29},
      {4'd14, 1'b0, 8'h2E},
      {4'd15, 1'b1, 8'h2F},
      {4'd3,  1'b0, 8'h23}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [7:0] d);
      @(negedge clk);
      io_addr = a;
      #1 d = io_rdata;
   endtask

   task automatic do_ack(output logic [7:0] v, output logic ok);
      @(negedge clk);
      ack = 1'b1;
      @(negedge clk);
      ack = 1'b0;
      ok = vec_valid_o;
      v = vec_o;
   endtask

   task automatic init_both();
      wr(16'h0020, 8'h11); wr(16'h0021, 8'h20); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
      wr(16'h00A0, 8'h11); wr(16'h00A1, 8'h28); wr(16'h00A1, 8'h02); wr(16'h00A1, 8'h01);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      logic [7:0] d, v;
      logic ok;
      idle(3);
      chk("R1 int after reset", int_o, 0);
      chk("R1 strobe after reset", vec_valid_o, 0);
      rst_n = 1'b1;
      idle(2);
      rd(16'h0021, d); chk("R1 primary mask", d, 8'hFF);
      rd(16'h00A1, d); chk("R1 secondary mask", d, 8'hFF);
      rd(16'h04D0, d); chk("R1 mode byte", d, 8'h00);

      wr(16'h04D0, 8'h20);
      wr(16'h04D1, 8'h80);
      rd(16'h04D0, d); chk("R2 primary mode byte", d, 8'h20);
      rd(16'h04D1, d); chk("R2 secondary mode byte", d, 8'h80);

      init_both();
      rd(16'h0021, d); chk("R13 mask cleared by init", d, 8'h00);

      for (int k = 0; k < 7; k++) begin
         int ln;
         ln = int'(TAB[k][12:9]);
         irq[ln] = 1'b1;
         idle(12);
         chk("R6 int raised", int_o, 1);
         do_ack(v, ok);
         chk("R7 strobe", ok, 1);
         chk(ln > 7 ? "R9 cascade vector" : "R7 vector", v, TAB[k][7:0]);
         chk("R6 int low after ack", int_o, 0);
         irq[ln] = 1'b0;
         idle(3);
         if (ln > 7) wr(16'h00A0, 8'h20);
         wr(16'h0020, 8'h20);
         idle(6);
      end

      // R3 edge mode
      irq[1] = 1'b1;
      idle(10);
      do_ack(v, ok); chk("R3 vector", v, 8'h21);
      rd(16'h0020, d); chk("R3 request cleared", d, 8'h00);
      idle(10);
      rd(16'h0020, d); chk("R3 no retrigger", d, 8'h00);
      wr(16'h0020, 8'h20);
      idle(10);
      chk("R3 int low after EOI", int_o, 0);
      irq[1] = 1'b0;
      idle(4);

      // R4 level mode, R5 drop, R8 spurious
      irq[5] = 1'b1;
      idle(10);
      do_ack(v, ok); chk("R4 vector", v, 8'h25);
      rd(16'h0020, d); chk("R4 request kept", d, 8'h20);
      wr(16'h0020, 8'h20);
      idle(6);
      chk("R4 int again after EOI", int_o, 1);
      irq[5] = 1'b0;
      idle(3);
      rd(16'h0020, d); chk("R5 request dropped", d, 8'h00);
      chk("R6 int held", int_o, 1);
      do_ack(v, ok); chk("R8 spurious vector", v, 8'h27);
      wr(16'h0020, 8'h0B);
      rd(16'h0020, d); chk("R8 in-service unchanged", d, 8'h00);
      wr(16'h0020, 8'h0A);
      chk("R8 int low", int_o, 0);

      // R10 mask
      wr(16'h0021, 8'h08);
      irq[3] = 1'b1;
      idle(10);
      chk("R10 masked", int_o, 0);
      wr(16'h0021, 8'h00);
      idle(6);
      chk("R10 unmasked", int_o, 1);
      do_ack(v, ok); chk("R10 vector", v, 8'h23);

      // R11 blocking
      irq[4] = 1'b1;
      idle(10);
      chk("R11 lower blocked", int_o, 0);
      irq[1] = 1'b1;
      idle(10);
      chk("R11 higher passes", int_o, 1);
      do_ack(v, ok); chk("R11 vector", v, 8'h21);
      wr(16'h0020, 8'h0B);
      rd(16'h0020, d); chk("R7 in-service bits", d, 8'h0A);
      irq[1] = 1'b0; irq[3] = 1'b0;

      // R12 EOI forms
      wr(16'h0020, 8'h20);
      rd(16'h0020, d); chk("R12 nonspecific EOI", d, 8'h08);
      idle(6);
      chk("R12 still blocked", int_o, 0);
      wr(16'h0020, 8'h63);
      rd(16'h0020, d); chk("R12 specific EOI", d, 8'h00);
      wr(16'h0020, 8'h0A);
      idle(6);
      chk("R12 pending released", int_o, 1);
      do_ack(v, ok); chk("R12 vector", v, 8'h24);
      wr(16'h0020, 8'h20);
      irq[4] = 1'b0;
      idle(4);

      // R13 reinitialisation
      irq[0] = 1'b1;
      idle(10);
      chk("R13 int before init", int_o, 1);
      wr(16'h0020, 8'h11);
      chk("R13 int lowered", int_o, 0);
      rd(16'h0021, d); chk("R13 mask cleared", d, 8'h00);
      wr(16'h0021, 8'h40); wr(16'h0021, 8'h04); wr(16'h0021, 8'h01);
      idle(10);
      chk("R13 no stale request", int_o, 0);
      irq[0] = 1'b0;
      idle(3);
      irq[0] = 1'b1;
      idle(10);
      do_ack(v, ok); chk("R13 new base", v, 8'h40);
      wr(16'h0020, 8'h20);
      irq[0] = 1'b0;
      idle(4);

      // R14 priority rotation
      wr(16'h0020, 8'hC3);
      irq[0] = 1'b1; irq[4] = 1'b1;
      idle(10);
      do_ack(v, ok); chk("R14 rotated winner", v, 8'h44);
      wr(16'h0020, 8'h20);
      idle(6);
      do_ack(v, ok); chk("R14 next winner", v, 8'h40);
      wr(16'h0020, 8'h20);
      irq[0] = 1'b0; irq[4] = 1'b0;
      idle(4);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule